// File: doc/BRIEF.md
# Translation Entry Update Engine

This block carries out software commands against a small translation table that maps device bus pages to system addresses. Each entry is a 64-bit word. Its two low bits hold the access rights: bit 0 grants device reads and bit 1 grants device writes. The remaining upper bits, above the page offset, give the translated address. The table's identifier, bus window base, page size and entry count are fixed by parameters. The entry storage sits inside the block and is zeroed by reset.

A command is accepted when `cmd_valid` is high while `cmd_ready` is high. The opcode on `cmd_op` selects one of four operations:
- 2'd0 writes one entry.
- 2'd1 reads one entry.
- 2'd2 fills a run of entries with one value.
- 2'd3 loads a run of entries from a list in system memory.

The list is read through a 64-bit read master. Each entry in the list is big-endian, so the byte at the lowest address is the most significant byte of the entry, and the bus carries that byte on data bits [7:0].

Completion is signalled by a one-cycle `done` pulse, with `err` marking a parameter error. Every entry write also raises a one-cycle notification carrying the page offset, the translated address, the offset mask and the access rights.

Top module: `tce_update_engine`

## Requirements
- R1: A command whose table identifier has any of bits [63:32] set, or whose bits [31:0] differ from `TABLE_ID`, ends with `err`=1 and writes no entry.
- R2: The command address is first rounded down to a page boundary. The entry index is (address − `BUS_OFFSET`) >> `PAGE_SHIFT`. An index of `NUM_ENTRIES` or more, including an address below the window, ends with `err`=1 and writes nothing.
- R3: A read (op 2'd1) with a valid index ends with `err`=0 and `rd_data` equal to the stored entry. A read with an out-of-range index ends with `err`=1.
- R4: A single write (op 2'd0) stores `cmd_val` at the indexed entry and ends with `err`=0. `cmd_count` is ignored for this op.
- R5: A fill (op 2'd2) with `cmd_count` of zero, or greater than `NUM_ENTRIES`, ends with `err`=1 and writes nothing. Otherwise it writes `cmd_val` to `cmd_count` consecutive pages.
- R6: A list load (op 2'd3) ends with `err`=1 and issues no memory read in any of these cases: `cmd_count` is zero, `cmd_count` exceeds `MAX_LIST` (512), or the list address in `cmd_val` has any of bits [11:0] set.
- R7: A list load reads slot i from address `cmd_val` + 8·i, with each read aligned to 8 bytes. It byte-reverses the returned data and writes the result to page i of the run.
- R8: A fill or list load stops at the first page whose index is out of range and ends with `err`=1. Entries written before that page keep their new values.
- R9: Each entry write raises `note_valid` for one cycle with these fields: `note_iova` = (address − `BUS_OFFSET`) masked to the page; `note_xlat` = entry with the page offset bits cleared; `note_mask` = page size − 1; `note_perm` = entry bits [1:0].
- R10: A memory read that returns `mem_rsp_err`=1 aborts a list load with `err`=1. Earlier pages stay written.
- R11: `cmd_ready` is low from the cycle after acceptance until completion. `done` is a single-cycle pulse.
- R12: Reset clears every table entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list load |
| cmd_tbl | input | 64 | Table identifier |
| cmd_addr | input | 64 | Device bus address |
| cmd_val | input | 64 | Entry value, or list address for op 3 |
| cmd_count | input | 64 | Page count for ops 2 and 3 |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Parameter error, valid with done |
| rd_data | output | 64 | Entry read, valid with done on op 1 |
| mem_req_valid | output | 1 | List read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_addr | output | 64 | List read byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data, lowest-address byte on [7:0] |
| mem_rsp_err | input | 1 | Read failed |
| note_valid | output | 1 | Entry-written notification |
| note_iova | output | 64 | Page offset within the window |
| note_xlat | output | 64 | Translated page address |
| note_mask | output | 64 | Offset mask |
| note_perm | output | 2 | [1] write allowed, [0] read allowed |

## Verification
The hardest case to reach is a multi-page command that fails partway through. To produce it, the stimulus starts a fill and a list load near the top of the window so that a later page runs past the last entry. It also plants a failing list slot in the memory model so that a fetch error interrupts a run. In each case the bench counts the notifications and the memory reads, then reads back both the entries written before the abort and those after it. This confirms that the earlier writes stayed and that nothing further was written.

// File: rtl/tce_upd_pkg.sv
package tce_upd_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_STEP,
        S_FETCH,
        S_WAIT
    } state_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } perm_t;

    typedef struct packed {
        logic [63:0] iova;
        logic [63:0] xlat;
        logic [63:0] mask;
        perm_t       perm;
    } note_t;

    function automatic logic [63:0] swap_bytes(input logic [63:0] d);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) begin
            r[8*b +: 8] = d[8*(7-b) +: 8];
        end
        return r;
    endfunction

    function automatic perm_t decode_perm(input logic [63:0] e);
        perm_t p;
        p.rd = e[0];
        p.wr = e[1];
        return p;
    endfunction

endpackage

// File: rtl/tce_cmd_check.sv
module tce_cmd_check
    import tce_upd_pkg::*;
#(
    parameter logic [31:0] TABLE_ID    = 32'h8000_0005,
    parameter int          NUM_ENTRIES = 16,
    parameter int          MAX_LIST    = 512,
    parameter int          LIST_ALIGN  = 12
) (
    input  op_e         op,
    input  logic [63:0] tbl,
    input  logic [63:0] count,
    input  logic [63:0] list_addr,
    output logic        reject
);
    logic id_bad, fill_bad, list_bad;

    always_comb begin
        id_bad   = (|tbl[63:32]) || (tbl[31:0] != TABLE_ID);
        fill_bad = (op == OP_FILL) &&
                   ((count == 64'd0) || (count > 64'(NUM_ENTRIES)));
        list_bad = (op == OP_LIST) &&
                   ((count == 64'd0) || (count > 64'(MAX_LIST)) ||
                    (|list_addr[LIST_ALIGN-1:0]));
        reject   = id_bad || fill_bad || list_bad;
    end
endmodule

// File: rtl/tce_index_calc.sv
module tce_index_calc #(
    parameter logic [63:0] BUS_OFFSET  = 64'h0010_0000,
    parameter int          PAGE_SHIFT  = 12,
    parameter int          NUM_ENTRIES = 16,
    localparam int         IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [63:0]      addr,
    output logic             in_range,
    output logic [IDX_W-1:0] idx,
    output logic [63:0]      iova
);
    localparam logic [63:0] PAGE_MASK = ~((64'd1 << PAGE_SHIFT) - 64'd1);

    logic [63:0] rel, full_idx;

    always_comb begin
        rel      = addr - BUS_OFFSET;
        full_idx = rel >> PAGE_SHIFT;
        in_range = full_idx < 64'(NUM_ENTRIES);
        idx      = full_idx[IDX_W-1:0];
        iova     = rel & PAGE_MASK;
    end
endmodule

// File: rtl/tce_table_mem.sv
module tce_table_mem #(
    parameter int  NUM_ENTRIES = 16,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [63:0]      wdata,
    output logic [63:0]      rdata
);
    logic [63:0] ent [NUM_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent[i] <= '0;
        end else if (we) begin
            ent[idx] <= wdata;
        end
    end

    assign rdata = ent[idx];
endmodule

// File: rtl/tce_update_engine.sv
module tce_update_engine
    import tce_upd_pkg::*;
#(
    parameter logic [31:0] TABLE_ID    = 32'h8000_0005,
    parameter logic [63:0] BUS_OFFSET  = 64'h0010_0000,
    parameter int          PAGE_SHIFT  = 12,
    parameter int          NUM_ENTRIES = 16,
    parameter int          MAX_LIST    = 512,
    parameter int          LIST_ALIGN  = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [63:0] cmd_tbl,
    input  logic [63:0] cmd_addr,
    input  logic [63:0] cmd_val,
    input  logic [63:0] cmd_count,
    output logic        done,
    output logic        err,
    output logic [63:0] rd_data,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [63:0] mem_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    input  logic        mem_rsp_err,
    output logic        note_valid,
    output logic [63:0] note_iova,
    output logic [63:0] note_xlat,
    output logic [63:0] note_mask,
    output logic [1:0]  note_perm
);
    localparam int          IDX_W     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [63:0] PAGE_SIZE = 64'd1 << PAGE_SHIFT;
    localparam logic [63:0] PAGE_MASK = ~(PAGE_SIZE - 64'd1);

    state_e      state;
    op_e         op_q;
    logic [63:0] tbl_q, addr_q, val_q, left_q, list_q;
    note_t       note_q;

    logic             reject, in_range, we;
    logic [IDX_W-1:0] idx;
    logic [63:0]      iova, rdata;

    tce_cmd_check #(
        .TABLE_ID(TABLE_ID), .NUM_ENTRIES(NUM_ENTRIES),
        .MAX_LIST(MAX_LIST), .LIST_ALIGN(LIST_ALIGN)
    ) u_check (
        .op(op_q), .tbl(tbl_q), .count(left_q), .list_addr(list_q), .reject(reject)
    );

    tce_index_calc #(
        .BUS_OFFSET(BUS_OFFSET), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENTRIES(NUM_ENTRIES)
    ) u_index (
        .addr(addr_q), .in_range(in_range), .idx(idx), .iova(iova)
    );

    tce_table_mem #(.NUM_ENTRIES(NUM_ENTRIES)) u_mem (
        .clk(clk), .rst(rst), .we(we), .idx(idx), .wdata(val_q), .rdata(rdata)
    );

    assign cmd_ready     = (state == S_IDLE);
    assign we            = (state == S_STEP) && in_range;
    assign mem_req_valid = (state == S_FETCH);
    assign mem_addr      = list_q;
    assign note_iova     = note_q.iova;
    assign note_xlat     = note_q.xlat;
    assign note_mask     = note_q.mask;
    assign note_perm     = note_q.perm;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            op_q       <= OP_PUT;
            tbl_q      <= '0;
            addr_q     <= '0;
            val_q      <= '0;
            left_q     <= '0;
            list_q     <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
            rd_data    <= '0;
            note_valid <= 1'b0;
            note_q     <= '0;
        end else begin
            done       <= 1'b0;
            note_valid <= 1'b0;
            unique case (state)
                S_IDLE: if (cmd_valid) begin
                    op_q   <= op_e'(cmd_op);
                    tbl_q  <= cmd_tbl;
                    addr_q <= cmd_addr & PAGE_MASK;
                    val_q  <= cmd_val;
                    list_q <= cmd_val;
                    left_q <= (op_e'(cmd_op) == OP_PUT) ? 64'd1 : cmd_count;
                    state  <= S_CHECK;
                end
                S_CHECK: begin
                    if (reject) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else if (op_q == OP_GET) begin
                        if (in_range) rd_data <= rdata;
                        done <= 1'b1; err <= !in_range; state <= S_IDLE;
                    end else if (op_q == OP_LIST) begin
                        state <= S_FETCH;
                    end else begin
                        state <= S_STEP;
                    end
                end
                S_STEP: begin
                    if (!in_range) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else begin
                        note_valid  <= 1'b1;
                        note_q.iova <= iova;
                        note_q.xlat <= val_q & PAGE_MASK;
                        note_q.mask <= ~PAGE_MASK;
                        note_q.perm <= decode_perm(val_q);
                        addr_q      <= addr_q + PAGE_SIZE;
                        left_q      <= left_q - 64'd1;
                        if (left_q == 64'd1) begin
                            done <= 1'b1; err <= 1'b0; state <= S_IDLE;
                        end else begin
                            state <= (op_q == OP_LIST) ? S_FETCH : S_STEP;
                        end
                    end
                end
                S_FETCH: if (mem_req_ready) begin
                    list_q <= list_q + 64'd8;
                    state  <= S_WAIT;
                end
                S_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else begin
                        val_q <= swap_bytes(mem_rsp_data);
                        state <= S_STEP;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: completion is a one-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: notified offset and address carry no bits inside the page
    a_r9_note_aligned: assert property (@(posedge clk) disable iff (rst)
        note_valid |-> (((note_iova & note_mask) == 64'd0) &&
                        ((note_xlat & note_mask) == 64'd0)));

    // R2: every notified page lies inside the table window
    a_r2_note_in_window: assert property (@(posedge clk) disable iff (rst)
        note_valid |-> ((note_iova >> PAGE_SHIFT) < 64'(NUM_ENTRIES)));

    // R7: list reads are 8-byte aligned
    a_r7_fetch_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_addr[2:0] == 3'd0));

    // R7: a stalled read request holds its address
    a_r7_fetch_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    // R11: no new command is taken while busy
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && cmd_valid) |=> !cmd_ready);
endmodule

// File: tb/test_tce_update_engine.sv
`timescale 1ns/1ps
module test_tce_update_engine;

    localparam logic [63:0] TID = 64'h8000_0005;

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] tbl;
        logic [63:0] addr;
        logic [63:0] val;
        logic [63:0] cnt;
        logic        e_err;
        logic [63:0] e_rd;
        logic [7:0]  e_notes;
        logic [7:0]  e_fetch;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{2'd1, TID, 64'h100000, 64'h0, 64'h0, 1'b0, 64'h0, 8'd0, 8'd0, 8'd12},                    // R12 cleared
        '{2'd0, TID, 64'h100123, 64'hDEAD_B000_0000_1003, 64'd9, 1'b0, 64'h0, 8'd1, 8'd0, 8'd4}, // R4
        '{2'd1, TID, 64'h100FFF, 64'h0, 64'h0, 1'b0, 64'hDEAD_B000_0000_1003, 8'd0, 8'd0, 8'd3}, // R3 R2 align
        '{2'd0, 64'h1_8000_0005, 64'h101000, 64'h7, 64'h0, 1'b1, 64'h0, 8'd0, 8'd0, 8'd1},       // R1 upper
        '{2'd0, 64'h8000_0006, 64'h101000, 64'h7, 64'h0, 1'b1, 64'h0, 8'd0, 8'd0, 8'd1},         // R1 mismatch
        '{2'd1, 64'h8000_0006, 64'h100000, 64'h0, 64'h0, 1'b1, 64'h0, 8'd0, 8'd0, 8'd1},         // R1 read
        '{2'd0, TID, 64'h110000, 64'h7, 64'h0, 1'b1, 64'h0, 8'd0, 8'd0, 8'd2},                   // R2 top
        '{2'd0, TID, 64'h0FF000, 64'h7, 64'h0, 1'b1, 64'h0, 8'd0, 8'd0, 8'd2},                   // R2 below
        '{2'd1, TID, 64'h110000, 64'h0, 64'h0, 1'b1, 64'h0, 8'd0, 8'd0, 8'd3},                   // R3 range
        '{2'd2, TID, 64'h102000, 64'h5555_0001, 64'd3, 1'b0, 64'h0, 8'd3, 8'd0, 8'd5},           // R5 fill
        '{2'd1, TID, 64'h104000, 64'h0, 64'h0, 1'b0, 64'h5555_0001, 8'd0, 8'd0, 8'd5},           // R5 last
        '{2'd1, TID, 64'h105000, 64'h0, 64'h0, 1'b0, 64'h0, 8'd0, 8'd0, 8'd5},                   // R5 beyond
        '{2'd2, TID, 64'h100000, 64'h9, 64'd17, 1'b1, 64'h0, 8'd0, 8'd0, 8'd5},                  // R5 too many
        '{2'd2, TID, 64'h100000, 64'h9, 64'd0, 1'b1, 64'h0, 8'd0, 8'd0, 8'd5},                   // R5 zero
        '{2'd2, TID, 64'h10E000, 64'h7777_0002, 64'd4, 1'b1, 64'h0, 8'd2, 8'd0, 8'd8},           // R8 fill abort
        '{2'd1, TID, 64'h10F000, 64'h0, 64'h0, 1'b0, 64'h7777_0002, 8'd0, 8'd0, 8'd8},           // R8 kept
        '{2'd3, TID, 64'h100000, 64'h2000_0000, 64'd513, 1'b1, 64'h0, 8'd0, 8'd0, 8'd6},         // R6 count
        '{2'd3, TID, 64'h100000, 64'h2000_0008, 64'd1, 1'b1, 64'h0, 8'd0, 8'd0, 8'd6},           // R6 align
        '{2'd3, TID, 64'h100000, 64'h2000_0000, 64'd0, 1'b1, 64'h0, 8'd0, 8'd0, 8'd6},           // R6 zero
        '{2'd3, TID, 64'h103000, 64'h2000_0000, 64'd2, 1'b0, 64'h0, 8'd2, 8'd2, 8'd7},           // R7 list
        '{2'd1, TID, 64'h103000, 64'h0, 64'h0, 1'b0, 64'h1234_5678_2000_0003, 8'd0, 8'd0, 8'd7}, // R7 slot 0
        '{2'd1, TID, 64'h104000, 64'h0, 64'h0, 1'b0, 64'h1234_5678_2000_000B, 8'd0, 8'd0, 8'd7}, // R7 slot 1
        '{2'd3, TID, 64'h10F000, 64'h2000_1000, 64'd3, 1'b1, 64'h0, 8'd1, 8'd2, 8'd8}            // R8 list abort
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [63:0] cmd_tbl = '0, cmd_addr = '0, cmd_val = '0, cmd_count = '0;
    logic        done, err;
    logic [63:0] rd_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        note_valid;
    logic [63:0] note_iova, note_xlat, note_mask;
    logic [1:0]  note_perm;

    int checks = 0, failures = 0;
    int note_cnt = 0, fetch_cnt = 0;
    logic [63:0] last_iova, last_xlat, last_mask;
    logic [1:0]  last_perm;
    logic [63:0] bad_addr = 64'hFFFF_FFFF_FFFF_FFF8;
    logic        got_err;
    logic [63:0] got_rd;

    always #4 clk = ~clk;

    tce_update_engine i_tce_update_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_tbl(cmd_tbl), .cmd_addr(cmd_addr), .cmd_val(cmd_val),
        .cmd_count(cmd_count), .done(done), .err(err), .rd_data(rd_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .note_valid(note_valid), .note_iova(note_iova), .note_xlat(note_xlat),
        .note_mask(note_mask), .note_perm(note_perm)
    );

    function automatic logic [63:0] be_bus(input logic [63:0] e);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = e[8*(7-b) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] list_entry(input logic [63:0] a);
        return {32'h1234_5678, a[31:0] | 32'h3};
    endfunction

    // memory model: one-cycle response
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            fetch_cnt     <= fetch_cnt + 1;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= be_bus(list_entry(mem_addr));
            mem_rsp_err   <= (mem_addr == bad_addr);
        end
    end

    always @(negedge clk) begin
        if (note_valid) begin
            note_cnt  <= note_cnt + 1;
            last_iova <= note_iova;
            last_xlat <= note_xlat;
            last_mask <= note_mask;
            last_perm <= note_perm;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [63:0] tbl, input logic [63:0] addr,
                           input logic [63:0] val, input logic [63:0] cnt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_tbl = tbl; cmd_addr = addr;
        cmd_val = val; cmd_count = cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        got_err = err;
        got_rd  = rd_data;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 ready after reset", 64'(cmd_ready), 64'd1);
        check("R11 done low after reset", 64'(done), 64'd0);

        for (int v = 0; v < NV; v++) begin
            int n0, f0;
            string tag;
            n0 = note_cnt;
            f0 = fetch_cnt;
            tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
            run_cmd(VEC[v].op, VEC[v].tbl, VEC[v].addr, VEC[v].val, VEC[v].cnt);
            check({tag, " err"}, 64'(got_err), 64'(VEC[v].e_err));
            if (VEC[v].op == 2'd1 && !VEC[v].e_err)
                check({tag, " rd_data"}, got_rd, VEC[v].e_rd);
            check({tag, " notes"}, 64'(note_cnt - n0), 64'(VEC[v].e_notes));
            check({tag, " fetches"}, 64'(fetch_cnt - f0), 64'(VEC[v].e_fetch));
        end

        // R9 notification fields, read-only entry
        run_cmd(2'd0, TID, 64'h105ABC, 64'hFFFF_FFFF_FFFF_F7F1, 64'd0);
        check("R9 iova", last_iova, 64'h5000);
        check("R9 xlat", last_xlat, 64'hFFFF_FFFF_FFFF_F000);
        check("R9 mask", last_mask, 64'hFFF);
        check("R9 perm", 64'(last_perm), 64'd1);

        // R10 memory error on second slot
        bad_addr = 64'h2000_2008;
        run_cmd(2'd3, TID, 64'h100000, 64'h2000_2000, 64'd3);
        check("R10 err", 64'(got_err), 64'd1);
        run_cmd(2'd1, TID, 64'h100000, 64'h0, 64'h0);
        check("R10 first kept", got_rd, 64'h1234_5678_2000_2003);
        run_cmd(2'd1, TID, 64'h101000, 64'h0, 64'h0);
        check("R10 second untouched", got_rd, 64'h0);

        // R11 busy and pulse width
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_tbl = TID; cmd_addr = 64'h108000;
        cmd_val = 64'h11; cmd_count = 64'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R11 ready low while busy", 64'(cmd_ready), 64'd0);
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R11 done one cycle", 64'(done), 64'd0);

        // R12 reset clears table
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_cmd(2'd1, TID, 64'h103000, 64'h0, 64'h0);
        check("R12 cleared by reset", got_rd, 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule